// File: doc/BRIEF.md
# Dual Down-Counter Timer with Masked Interrupt Controller

This block holds two 16-bit down-counters and a seven-source interrupt flag and enable pair. A processor reaches them through a 4-bit register address and a byte-wide data bus. The first timer either fires once after it is started or reloads itself from its latches on every underflow. In the reload mode it can also produce a square wave on an output bit. The second timer only fires once after it is started. Five more flag sources enter as external set pulses. The interrupt request is raised while any flag that is set is also enabled.

Some accesses have side effects. Writing the high byte of a timer starts it. Reading the low counter byte of a timer stops it. Both of these clear that timer's flag. A three-bit mode input carries the auxiliary control bits. The block can also stand in for bit 7 of a port B read value that it takes from outside.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the counters, latches, flags and enables are all zero, both timers are stopped and disarmed, `t1_out_o` is 1 and `irq_o` is 0.
- R2: Writing register 4 or 6 stores the timer 1 low latch, and writing register 7 stores the high latch. Registers 6 and 7 read back these latches. Writing register 5 stores the high latch and loads the counter with {data, low latch} at that edge. The same write clears flag 6, starts and arms timer 1, and drives `t1_out_o` to 0.
- R3: A running counter decrements by one on each clock edge. A counter loaded with N underflows on the (N+1)-th edge after the load. In single-shot operation it then wraps to 0xFFFF and keeps counting. Registers 5 and 9 read the high byte of the counters.
- R4: When `mode_i[1]` is 1 (free-running), every timer 1 underflow sets flag 6, inverts `t1_out_o` and reloads the counter from {high latch, low latch}.
- R5: When `mode_i[1]` is 0, only the first timer 1 underflow after arming sets flag 6 and drives `t1_out_o` to 1. After that, `t1_out_o` stays 1 and later underflows set no flag.
- R6: Reading register 4 returns the low byte of the timer 1 counter. The read also clears flag 6, stops and disarms timer 1, and drives `t1_out_o` to 1. A stopped counter holds its value.
- R7: Timer 2 decrements only while `mode_i[0]` is 0. Writing register 8 stores its low latch. Writing register 9 loads {data, low latch}, clears flag 5, and starts and arms the timer. Its first underflow after arming sets flag 5. Reading register 8 returns the low counter byte, clears flag 5, and stops and disarms the timer.
- R8: `ext_flag_i[k]` set to 1 on an edge sets flag k (k = 0..4). When a set and a clear reach the same flag on the same edge, the set wins.
- R9: Writing register 13 clears every flag in bits 6:0 whose data bit is 1. Reading register 13 returns {irq, flags[6:0]}.
- R10: Writing register 14 with data bit 7 = 1 sets the enables marked by data bits 6:0. With data bit 7 = 0 it clears them. Reading register 14 returns {1, enables[6:0]}.
- R11: `irq_o` is 1 exactly when (flags[6:0] & enables[6:0]) is nonzero.
- R12: Reading register 0 returns `portb_i`, except that bit 7 is replaced by `t1_out_o` when `mode_i[2]` is 1. Registers 1 to 3, 10 to 12 and 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Register access strobe for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| mode_i | input | 3 | [2] timer output on port B bit 7, [1] timer 1 free-running, [0] timer 2 hold |
| portb_i | input | 8 | External port B value for register 0 reads |
| ext_flag_i | input | 5 | Set pulses for flags 4:0 |
| t1_out_o | output | 1 | Timer 1 output bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit bus and 16-bit counters. In the random phase, high counter bytes are kept mostly at zero. This keeps underflows, reloads and output toggles frequent, so they overlap with accesses, external pulses and mode changes. One directed run lets a single-shot counter wrap through the full 16-bit range. This confirms that a second underflow raises no flag.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int DW    = 8;
  localparam int CW    = 2 * DW;
  localparam int NFLG  = 7;
  localparam int NEXT  = 5;
  localparam int AW    = 4;

  localparam logic [AW-1:0] A_PORTB  = 4'd0;
  localparam logic [AW-1:0] A_T1_LO  = 4'd4;
  localparam logic [AW-1:0] A_T1_HI  = 4'd5;
  localparam logic [AW-1:0] A_T1_LL  = 4'd6;
  localparam logic [AW-1:0] A_T1_LH  = 4'd7;
  localparam logic [AW-1:0] A_T2_LO  = 4'd8;
  localparam logic [AW-1:0] A_T2_HI  = 4'd9;
  localparam logic [AW-1:0] A_FLAGS  = 4'd13;
  localparam logic [AW-1:0] A_ENABLE = 4'd14;

  localparam int F_T1 = 6;
  localparam int F_T2 = 5;

  localparam int M_OUT_PB = 2;
  localparam int M_FREE   = 1;
  localparam int M_T2HOLD = 0;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (step_i) begin
      if (cnt_q == '0)  cnt_q <= reload_i ? reload_val_i : '1;
      else              cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: single-shot wrap lands on all ones
  a_r3_wrap_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !reload_i |=> cnt_o == '1);
  // R3/R6: no step and no load keeps the value
  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !load_i |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_wr_i,
  input  logic         en_set_i,
  input  logic [N-1:0] en_sel_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic f_q, e_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) f_q <= 1'b0;
      else         f_q <= (f_q & ~clr_i[k]) | set_i[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      e_q <= 1'b0;
      else if (en_wr_i && en_sel_i[k])  e_q <= en_set_i;
    end

    assign flags_o[k] = f_q;
    assign en_o[k]    = e_q;

    // R8: set beats clear
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flags_o[k]);
    // R9: lone clear empties the flag
    a_r9_clear_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] && !set_i[k] |=> !flags_o[k]);
    // R10: set/clear enable write
    a_r10_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_wr_i && en_sel_i[k] |=> en_o[k] == $past(en_set_i));
  end

  assign irq_o = |(flags_o & en_o);
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [2:0]      mode_i,
  input  logic [DW-1:0]   portb_i,
  input  logic [NEXT-1:0] ext_flag_i,
  output logic            t1_out_o,
  output logic            irq_o
);
  logic wr, rd;
  logic wr_t1_hi, rd_t1_lo, wr_t2_hi, rd_t2_lo, wr_flags, wr_en;
  logic [DW-1:0] t1_ll_q, t1_lh_q, t2_ll_q;
  logic t1_on_q, t1_arm_q, t1_out_q, t2_on_q, t2_arm_q;
  logic [CW-1:0] t1_cnt, t2_cnt;
  logic t1_wrap, t2_wrap, t1_ev, t2_ev, t1_free;
  logic [NFLG-1:0] set_v, clr_v, flags, enables;

  assign wr       = cs_i && we_i;
  assign rd       = cs_i && !we_i;
  assign wr_t1_hi = wr && addr_i == A_T1_HI;
  assign rd_t1_lo = rd && addr_i == A_T1_LO;
  assign wr_t2_hi = wr && addr_i == A_T2_HI;
  assign rd_t2_lo = rd && addr_i == A_T2_LO;
  assign wr_flags = wr && addr_i == A_FLAGS;
  assign wr_en    = wr && addr_i == A_ENABLE;
  assign t1_free  = mode_i[M_FREE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_ll_q <= '0;
      t1_lh_q <= '0;
      t2_ll_q <= '0;
    end else if (wr) begin
      if (addr_i == A_T1_LO || addr_i == A_T1_LL) t1_ll_q <= wdata_i;
      if (addr_i == A_T1_HI || addr_i == A_T1_LH) t1_lh_q <= wdata_i;
      if (addr_i == A_T2_LO)                      t2_ll_q <= wdata_i;
    end
  end

  tmr_count #(.W(CW)) u_t1 (
    .clk_i, .rst_ni,
    .load_i      (wr_t1_hi),
    .load_val_i  ({wdata_i, t1_ll_q}),
    .step_i      (t1_on_q && !rd_t1_lo),
    .reload_i    (t1_free),
    .reload_val_i({t1_lh_q, t1_ll_q}),
    .cnt_o       (t1_cnt),
    .wrap_o      (t1_wrap)
  );

  tmr_count #(.W(CW)) u_t2 (
    .clk_i, .rst_ni,
    .load_i      (wr_t2_hi),
    .load_val_i  ({wdata_i, t2_ll_q}),
    .step_i      (t2_on_q && !mode_i[M_T2HOLD] && !rd_t2_lo),
    .reload_i    (1'b0),
    .reload_val_i('0),
    .cnt_o       (t2_cnt),
    .wrap_o      (t2_wrap)
  );

  assign t1_ev = t1_wrap && (t1_free || t1_arm_q);
  assign t2_ev = t2_wrap && t2_arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_on_q  <= 1'b0;
      t1_arm_q <= 1'b0;
      t1_out_q <= 1'b1;
    end else if (wr_t1_hi) begin
      t1_on_q  <= 1'b1;
      t1_arm_q <= 1'b1;
      t1_out_q <= 1'b0;
    end else if (rd_t1_lo) begin
      t1_on_q  <= 1'b0;
      t1_arm_q <= 1'b0;
      t1_out_q <= 1'b1;
    end else if (t1_wrap) begin
      if (t1_free) t1_out_q <= ~t1_out_q;
      else if (t1_arm_q) begin
        t1_out_q <= 1'b1;
        t1_arm_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t2_on_q  <= 1'b0;
      t2_arm_q <= 1'b0;
    end else if (wr_t2_hi) begin
      t2_on_q  <= 1'b1;
      t2_arm_q <= 1'b1;
    end else if (rd_t2_lo) begin
      t2_on_q  <= 1'b0;
      t2_arm_q <= 1'b0;
    end else if (t2_ev) begin
      t2_arm_q <= 1'b0;
    end
  end

  assign t1_out_o = t1_out_q;

  always_comb begin
    set_v             = '0;
    set_v[NEXT-1:0]   = ext_flag_i;
    set_v[F_T1]       = t1_ev;
    set_v[F_T2]       = t2_ev;
    clr_v             = wr_flags ? wdata_i[NFLG-1:0] : '0;
    clr_v[F_T1]       = clr_v[F_T1] | wr_t1_hi | rd_t1_lo;
    clr_v[F_T2]       = clr_v[F_T2] | wr_t2_hi | rd_t2_lo;
  end

  tmr_irq_flags #(.N(NFLG)) u_flags (
    .clk_i, .rst_ni,
    .set_i   (set_v),
    .clr_i   (clr_v),
    .en_wr_i (wr_en),
    .en_set_i(wdata_i[DW-1]),
    .en_sel_i(wdata_i[NFLG-1:0]),
    .flags_o (flags),
    .en_o    (enables),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (addr_i)
      A_PORTB:  rdata_o = {mode_i[M_OUT_PB] ? t1_out_q : portb_i[DW-1], portb_i[DW-2:0]};
      A_T1_LO:  rdata_o = t1_cnt[DW-1:0];
      A_T1_HI:  rdata_o = t1_cnt[CW-1:DW];
      A_T1_LL:  rdata_o = t1_ll_q;
      A_T1_LH:  rdata_o = t1_lh_q;
      A_T2_LO:  rdata_o = t2_cnt[DW-1:0];
      A_T2_HI:  rdata_o = t2_cnt[CW-1:DW];
      A_FLAGS:  rdata_o = {irq_o, flags};
      A_ENABLE: rdata_o = {1'b1, enables};
      default:  rdata_o = '0;
    endcase
  end

  // R2: start loads counter, output low
  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_t1_hi |=> t1_cnt == {$past(wdata_i), $past(t1_ll_q)} && !t1_out_o);
  // R4: free-running underflow toggles output
  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_free && t1_wrap |=> t1_out_o != $past(t1_out_o));
  // R5: single-shot output stays high
  a_r5_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t1_free && t1_out_o && !wr_t1_hi |=> t1_out_o);
  // R6: low byte read stops timer 1
  a_r6_read_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_t1_lo |=> t1_out_o && $stable(t1_cnt));
  // R7: hold mode freezes timer 2
  a_r7_t2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[M_T2HOLD] && !wr_t2_hi |=> $stable(t2_cnt));
endmodule

// File: tb/tmr_irq_unit_test.sv
`timescale 1ns/1ps
module tmr_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, pb = '0;
  logic [2:0] mode = '0;
  logic [4:0] ext = '0;
  logic [7:0] rdata;
  logic       t1_out, irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_c1, m_c2;
  logic [7:0]  m_ll1, m_lh1, m_ll2;
  logic        m_on1, m_arm1, m_out, m_on2, m_arm2;
  logic [6:0]  m_fl, m_en;

  tmr_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mode_i(mode), .portb_i(pb),
    .ext_flag_i(ext), .t1_out_o(t1_out), .irq_o(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic m_irq();
    return |(m_fl & m_en);
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0:    return {mode[2] ? m_out : pb[7], pb[6:0]};
      4'd4:    return m_c1[7:0];
      4'd5:    return m_c1[15:8];
      4'd6:    return m_ll1;
      4'd7:    return m_lh1;
      4'd8:    return m_c2[7:0];
      4'd9:    return m_c2[15:8];
      4'd13:   return {m_irq(), m_fl};
      4'd14:   return {1'b1, m_en};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'd0:              return "R12";
      4'd4:              return "R6";
      4'd5, 4'd9:        return "R3";
      4'd6, 4'd7:        return "R2";
      4'd8:              return "R7";
      4'd13:             return "R9";
      4'd14:             return "R10";
      default:           return "R12";
    endcase
  endfunction

  task automatic m_reset();
    m_c1 = 0; m_c2 = 0; m_ll1 = 0; m_lh1 = 0; m_ll2 = 0;
    m_on1 = 0; m_arm1 = 0; m_out = 1; m_on2 = 0; m_arm2 = 0;
    m_fl = 0; m_en = 0;
  endtask

  task automatic m_step();
    logic [6:0] st, cl;
    logic w, r;
    st = '0; cl = '0;
    w = cs && we; r = cs && !we;
    if (w && addr == 4'd5) begin
      m_c1 = {wdata, m_ll1}; m_on1 = 1; m_arm1 = 1; m_out = 0; cl[6] = 1;
    end else if (r && addr == 4'd4) begin
      m_on1 = 0; m_arm1 = 0; m_out = 1; cl[6] = 1;
    end else if (m_on1) begin
      if (m_c1 == 16'h0) begin
        if (mode[1]) begin
          m_c1 = {m_lh1, m_ll1}; m_out = ~m_out; st[6] = 1;
        end else begin
          m_c1 = 16'hFFFF;
          if (m_arm1) begin st[6] = 1; m_out = 1; m_arm1 = 0; end
        end
      end else m_c1 = m_c1 - 16'd1;
    end
    if (w && addr == 4'd9) begin
      m_c2 = {wdata, m_ll2}; m_on2 = 1; m_arm2 = 1; cl[5] = 1;
    end else if (r && addr == 4'd8) begin
      m_on2 = 0; m_arm2 = 0; cl[5] = 1;
    end else if (m_on2 && !mode[0]) begin
      if (m_c2 == 16'h0) begin
        m_c2 = 16'hFFFF;
        if (m_arm2) begin st[5] = 1; m_arm2 = 0; end
      end else m_c2 = m_c2 - 16'd1;
    end
    if (w && (addr == 4'd4 || addr == 4'd6)) m_ll1 = wdata;
    if (w && (addr == 4'd5 || addr == 4'd7)) m_lh1 = wdata;
    if (w && addr == 4'd8) m_ll2 = wdata;
    if (w && addr == 4'd13) cl = cl | wdata[6:0];
    st[4:0] = ext;
    m_fl = (m_fl & ~cl) | st;
    if (w && addr == 4'd14) m_en = wdata[7] ? (m_en | wdata[6:0]) : (m_en & ~wdata[6:0]);
  endtask

  // one bus cycle; called at a negedge, returns at the next negedge
  task automatic tick(input logic c, input logic w, input logic [3:0] a,
                      input logic [7:0] d, output logic [7:0] v);
    cs = c; we = w; addr = a; wdata = d;
    #1;
    v = rdata;
    if (c && !w) check(req_of(a), {8'h0, rdata}, {8'h0, m_read(a)});
    @(posedge clk);
    m_step();
    @(negedge clk);
    cs = 0; we = 0; ext = '0;
    check("R11", {15'h0, irq}, {15'h0, m_irq()});
    check("R4", {15'h0, t1_out}, {15'h0, m_out});
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] v;
    tick(1, 1, a, d, v);
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    tick(1, 0, a, 8'h00, v);
    check(req, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic idle(input int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) tick(0, 0, 4'd0, 8'h00, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v1, v2;
    void'($urandom(32'd20240611));
    m_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", {15'h0, t1_out}, 16'h1);
    check("R1", {15'h0, irq}, 16'h0);
    rd_exp(4'd4, 8'h00, "R1");
    rd_exp(4'd5, 8'h00, "R1");
    rd_exp(4'd6, 8'h00, "R1");
    rd_exp(4'd9, 8'h00, "R1");
    rd_exp(4'd13, 8'h00, "R1");
    rd_exp(4'd14, 8'h80, "R1");

    // R2/R3/R5 single-shot timer 1 loaded with 3
    mode = 3'b000;
    wr_reg(4'd6, 8'h03);
    rd_exp(4'd6, 8'h03, "R2");
    wr_reg(4'd5, 8'h00);
    check("R2", {15'h0, t1_out}, 16'h0);
    idle(3);
    rd_exp(4'd13, 8'h00, "R3");
    rd_exp(4'd13, 8'h40, "R3");
    check("R5", {15'h0, t1_out}, 16'h1);
    rd_exp(4'd5, 8'hFF, "R3");
    wr_reg(4'd14, 8'hC0);
    check("R11", {15'h0, irq}, 16'h1);
    rd_exp(4'd14, 8'hC0, "R10");
    rd_exp(4'd13, 8'hC0, "R9");
    wr_reg(4'd13, 8'h40);
    check("R9", {15'h0, irq}, 16'h0);
    idle(65540);
    rd_exp(4'd13, 8'h00, "R5");
    check("R5", {15'h0, t1_out}, 16'h1);

    // R6 stop by low-byte read
    rd_exp(4'd4, m_c1[7:0], "R6");
    check("R6", {15'h0, t1_out}, 16'h1);

    // R4 free-running with latch 2
    mode = 3'b010;
    wr_reg(4'd6, 8'h02);
    wr_reg(4'd7, 8'h00);
    rd_exp(4'd7, 8'h00, "R2");
    wr_reg(4'd5, 8'h00);
    idle(2);
    check("R4", {15'h0, t1_out}, 16'h0);
    idle(1);
    check("R4", {15'h0, t1_out}, 16'h1);
    rd_exp(4'd13, 8'hC0, "R4");
    idle(2);
    check("R4", {15'h0, t1_out}, 16'h0);

    // R6 a stopped counter holds
    tick(1, 0, 4'd4, 8'h00, v1);
    idle(3);
    tick(1, 0, 4'd4, 8'h00, v2);
    check("R6", {8'h0, v2}, {8'h0, v1});

    // R7 timer 2 hold, then count and flag
    wr_reg(4'd13, 8'h7F);
    wr_reg(4'd14, 8'hFF);
    rd_exp(4'd14, 8'hFF, "R10");
    mode = 3'b001;
    wr_reg(4'd8, 8'h01);
    wr_reg(4'd9, 8'h00);
    idle(5);
    rd_exp(4'd8, 8'h01, "R7");
    wr_reg(4'd9, 8'h00);
    mode = 3'b000;
    idle(2);
    rd_exp(4'd13, 8'hA0, "R7");
    wr_reg(4'd13, 8'h20);
    rd_exp(4'd13, 8'h00, "R9");

    // R8 external set beats clear on the same edge
    ext = 5'h15;
    wr_reg(4'd13, 8'h1F);
    rd_exp(4'd13, 8'h95, "R8");
    wr_reg(4'd13, 8'h1F);
    rd_exp(4'd13, 8'h00, "R8");
    check("R11", {15'h0, irq}, 16'h0);

    // R10 enable clear
    wr_reg(4'd14, 8'h40);
    rd_exp(4'd14, 8'hBF, "R10");

    // R12 port B read
    pb = 8'h3C;
    mode = 3'b100;
    rd_exp(4'd0, 8'hBC, "R12");
    mode = 3'b000;
    rd_exp(4'd0, 8'h3C, "R12");
    rd_exp(4'd3, 8'h00, "R12");
    rd_exp(4'd11, 8'h00, "R12");

    // random mix, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic c, w;
      if ($urandom % 16 == 0) mode = 3'($urandom);
      if ($urandom % 8 == 0) ext = 5'($urandom);
      pb = 8'($urandom);
      c = ($urandom % 2) == 1;
      w = ($urandom % 2) == 1;
      a = 4'($urandom);
      d = 8'($urandom);
      if (a == 4'd5 || a == 4'd9 || a == 4'd7) d = ($urandom % 4 == 0) ? d : 8'h00;
      if (a == 4'd4 || a == 4'd6 || a == 4'd8) d = d % 8'd16;
      if (a == 4'd4 && !w && $urandom % 4 != 0) c = 0;
      tick(c, w, a, d, v1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule